// File: doc/BRIEF.md
# Double-Buffered Catch-All Receive Object

This block is the storage end of a receive object that takes every frame no other object claimed. Frames arrive on a single-cycle store strobe with identifier, length code, a remote flag and up to eight data bytes. They land in one of two hidden buffers, picked in a fixed order. The host sees one buffer at a time, always the older of the two that hold a frame. When it has finished with that frame it pulses a release, and the next frame, if any, comes into view.

When both buffers are full, a new frame overwrites the buffer written most recently and raises a sticky lost flag. The frame the host is waiting to read is never destroyed. While any buffer holds a frame and receive interrupts are enabled, the block presents a fixed interrupt code to the host's interrupt logic.

Top module: `catchall_rx_obj`

## Requirements
- R1: With both buffers free, a stored frame goes into buffer 1. Bit 0 of `alloc_o` is buffer 1 and bit 1 is buffer 2; a set bit means the buffer is allocated.
- R2: With exactly one buffer free, a stored frame goes into that free buffer.
- R3: With both buffers allocated, a stored frame overwrites the buffer written most recently and sets `msglst_o`. The older buffer is left untouched.
- R4: A data frame (`st_rmt_i`=0) stores identifier, length code and data bytes. A remote frame (`st_rmt_i`=1) stores only the identifier, keeps that buffer's previous length code and data, and marks the buffer as remote.
- R5: The visible buffer is the older allocated buffer; with none allocated it is buffer 1. `newdat_o` is 1 when the visible buffer is allocated. `rmtpnd_o` is 1 when it is allocated and holds a remote frame. `intpnd_o` is 1 when it is allocated and `rx_ie_i` is 1.
- R6: `rel_i` frees the visible buffer. A release with no buffer allocated changes nothing.
- R7: `irq_code_o` is 8'h02 while any buffer is allocated and `rx_ie_i` is 1, and 8'h00 otherwise.
- R8: `msglst_o` stays set until `lost_clr_i` is pulsed. When a clear and an overflowing store come in the same cycle, the flag ends up set.
- R9: When a store and a release come in the same cycle, the release is applied first and the store is then placed according to R1 to R3.
- R10: After reset, both buffers are free, all flags are 0, `irq_code_o` is 0, and identifier, length code and data read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_i | input | 1 | Single-cycle strobe to store a frame |
| st_id_i | input | 11 | Identifier of the incoming frame |
| st_dlc_i | input | 4 | Length code of the incoming frame |
| st_rmt_i | input | 1 | 1 = remote frame, 0 = data frame |
| st_data_i | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rel_i | input | 1 | Host releases the visible buffer |
| lost_clr_i | input | 1 | Host clears the lost flag |
| rx_ie_i | input | 1 | Receive interrupt enable |
| id_o | output | 11 | Identifier of the visible buffer |
| dlc_o | output | 4 | Length code of the visible buffer |
| data_o | output | 64 | Data bytes of the visible buffer |
| newdat_o | output | 1 | Visible buffer holds an unread frame |
| rmtpnd_o | output | 1 | Visible buffer holds a remote frame |
| intpnd_o | output | 1 | Interrupt pending for the visible buffer |
| msglst_o | output | 1 | A frame was overwritten |
| alloc_o | output | 2 | Allocation status of buffers 1 and 2 |
| irq_code_o | output | 8 | Interrupt identifier code |

## Verification
The bench drives an overflow and then checks that the older frame is still visible and the newer one was replaced. A design that overwrote the oldest buffer, or the visible one, would show the wrong identifier. A remote frame lands on a buffer that previously held data, and the bench checks that the length code and data survive; a design that stored all fields would lose them. Same-cycle release and store are driven with both buffers full, which must not raise the lost flag; a design that stored before releasing would set it. The bench also drives a lost-flag clear together with an overflow, which must leave the flag set, and a release with nothing allocated, which must leave the state alone.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
    localparam int RXO_ID_W   = 11;
    localparam int RXO_DLC_W  = 4;
    localparam int RXO_NBYTES = 8;
    localparam int RXO_DATA_W = RXO_NBYTES * 8;
    localparam int RXO_NBUF   = 2;
    localparam int RXO_CODE_W = 8;
    localparam logic [RXO_CODE_W-1:0] RXO_IRQ_CODE = 8'h02;

    typedef struct packed {
        logic [RXO_ID_W-1:0]   id;
        logic [RXO_DLC_W-1:0]  dlc;
        logic [RXO_DATA_W-1:0] data;
        logic                  rmt;
    } rxo_buf_t;

    typedef struct packed {
        logic [RXO_NBUF-1:0] alloc;
        logic                last;
        logic                lost;
    } rxo_ctl_t;
endpackage

// File: rtl/rxo_alloc.sv
module rxo_alloc
    import rxo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                store_i,
    input  logic                rel_i,
    input  logic                lost_clr_i,
    output logic [RXO_NBUF-1:0] wr_en_o,
    output logic                head_o,
    output logic [RXO_NBUF-1:0] alloc_o,
    output logic                lost_o
);
    rxo_ctl_t ctl_d, ctl_q;
    logic     head;
    logic [RXO_NBUF-1:0] alloc_rel;
    logic     tgt;

    // Older buffer: with both full it is the one not written last.
    always_comb begin
        if (ctl_q.alloc == 2'b11)      head = ~ctl_q.last;
        else if (ctl_q.alloc == 2'b10) head = 1'b1;
        else                           head = 1'b0;
    end

    always_comb begin
        ctl_d     = ctl_q;
        wr_en_o   = '0;
        tgt       = 1'b0;
        alloc_rel = ctl_q.alloc;
        // Release first, then the store sees the freed buffer.
        if (rel_i) alloc_rel[head] = 1'b0;
        if (lost_clr_i) ctl_d.lost = 1'b0;
        if (store_i) begin
            if (alloc_rel == 2'b11) begin
                tgt        = ctl_q.last;
                ctl_d.lost = 1'b1;
            end else if (!alloc_rel[0]) begin
                tgt = 1'b0;
            end else begin
                tgt = 1'b1;
            end
            wr_en_o[tgt]   = 1'b1;
            alloc_rel[tgt] = 1'b1;
            ctl_d.last     = tgt;
        end
        ctl_d.alloc = alloc_rel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign head_o  = head;
    assign alloc_o = ctl_q.alloc;
    assign lost_o  = ctl_q.lost;
endmodule

// File: rtl/rxo_buf.sv
module rxo_buf
    import rxo_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  rmt_i,
    input  logic [RXO_ID_W-1:0]   id_i,
    input  logic [RXO_DLC_W-1:0]  dlc_i,
    input  logic [RXO_DATA_W-1:0] data_i,
    output rxo_buf_t              q_o
);
    rxo_buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (wr_i) begin
            buf_d.id  = id_i;
            buf_d.rmt = rmt_i;
            if (!rmt_i) begin
                buf_d.dlc  = dlc_i;
                buf_d.data = data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign q_o = buf_q;
endmodule

// File: rtl/catchall_rx_obj.sv
module catchall_rx_obj
    import rxo_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  store_i,
    input  logic [RXO_ID_W-1:0]   st_id_i,
    input  logic [RXO_DLC_W-1:0]  st_dlc_i,
    input  logic                  st_rmt_i,
    input  logic [RXO_DATA_W-1:0] st_data_i,
    input  logic                  rel_i,
    input  logic                  lost_clr_i,
    input  logic                  rx_ie_i,
    output logic [RXO_ID_W-1:0]   id_o,
    output logic [RXO_DLC_W-1:0]  dlc_o,
    output logic [RXO_DATA_W-1:0] data_o,
    output logic                  newdat_o,
    output logic                  rmtpnd_o,
    output logic                  intpnd_o,
    output logic                  msglst_o,
    output logic [RXO_NBUF-1:0]   alloc_o,
    output logic [RXO_CODE_W-1:0] irq_code_o
);
    logic [RXO_NBUF-1:0] wr_en;
    logic                head;
    logic [RXO_NBUF-1:0] alloc;
    logic                lost;
    rxo_buf_t            bufs [RXO_NBUF];
    rxo_buf_t            view;

    rxo_alloc u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_i    (store_i),
        .rel_i      (rel_i),
        .lost_clr_i (lost_clr_i),
        .wr_en_o    (wr_en),
        .head_o     (head),
        .alloc_o    (alloc),
        .lost_o     (lost)
    );

    for (genvar g = 0; g < RXO_NBUF; g++) begin : g_buf
        rxo_buf u_buf (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (wr_en[g]),
            .rmt_i  (st_rmt_i),
            .id_i   (st_id_i),
            .dlc_i  (st_dlc_i),
            .data_i (st_data_i),
            .q_o    (bufs[g])
        );
    end

    assign view       = bufs[head];
    assign id_o       = view.id;
    assign dlc_o      = view.dlc;
    assign data_o     = view.data;
    assign newdat_o   = alloc[head];
    assign rmtpnd_o   = alloc[head] & view.rmt;
    assign intpnd_o   = alloc[head] & rx_ie_i;
    assign msglst_o   = lost;
    assign alloc_o    = alloc;
    assign irq_code_o = ((|alloc) && rx_ie_i) ? RXO_IRQ_CODE : '0;
endmodule

// File: rtl/rxo_chk.sv
module rxo_chk
    import rxo_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  store_i,
    input logic                  st_rmt_i,
    input logic                  rel_i,
    input logic                  lost_clr_i,
    input logic                  rx_ie_i,
    input logic [RXO_DATA_W-1:0] data_o,
    input logic                  newdat_o,
    input logic                  msglst_o,
    input logic [RXO_NBUF-1:0]   alloc_o,
    input logic [RXO_CODE_W-1:0] irq_code_o
);
    AST_FIRST_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        store_i && !rel_i && alloc_o == 2'b00 |=> alloc_o == 2'b01); // R1
    AST_OVF_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        store_i && !rel_i && alloc_o == 2'b11 |=> msglst_o && alloc_o == 2'b11); // R3
    AST_RMT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        store_i && st_rmt_i && !rel_i && alloc_o == 2'b00 |=> $stable(data_o)); // R4
    AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_i |=> newdat_o); // R5
    AST_NO_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_o == 2'b00 |-> irq_code_o == '0); // R7
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        msglst_o && !lost_clr_i |=> msglst_o); // R8
    AST_REL_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        store_i && rel_i && !lost_clr_i && !msglst_o && alloc_o == 2'b11 |=> !msglst_o); // R9
endmodule

bind catchall_rx_obj rxo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_i    (store_i),
    .st_rmt_i   (st_rmt_i),
    .rel_i      (rel_i),
    .lost_clr_i (lost_clr_i),
    .rx_ie_i    (rx_ie_i),
    .data_o     (data_o),
    .newdat_o   (newdat_o),
    .msglst_o   (msglst_o),
    .alloc_o    (alloc_o),
    .irq_code_o (irq_code_o)
);

// File: tb/tb_catchall_rx_obj.sv
module tb_catchall_rx_obj;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        store_i = 1'b0;
    logic [10:0] st_id_i = '0;
    logic [3:0]  st_dlc_i = '0;
    logic        st_rmt_i = 1'b0;
    logic [63:0] st_data_i = '0;
    logic        rel_i = 1'b0;
    logic        lost_clr_i = 1'b0;
    logic        rx_ie_i = 1'b1;
    logic [10:0] id_o;
    logic [3:0]  dlc_o;
    logic [63:0] data_o;
    logic        newdat_o, rmtpnd_o, intpnd_o, msglst_o;
    logic [1:0]  alloc_o;
    logic [7:0]  irq_code_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    catchall_rx_obj dut (.*);

    typedef struct packed {
        logic        st;
        logic        rl;
        logic        rm;
        logic [10:0] id;
        logic [1:0]  e_alloc;
        logic [10:0] e_id;
        logic        e_nd;
        logic        e_rm;
        logic        e_lost;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{1'b1,1'b0,1'b0,11'h100, 2'b01,11'h100,1'b1,1'b0,1'b0}, // R1
        '{1'b1,1'b0,1'b0,11'h101, 2'b11,11'h100,1'b1,1'b0,1'b0}, // R2
        '{1'b1,1'b0,1'b0,11'h102, 2'b11,11'h100,1'b1,1'b0,1'b1}, // R3
        '{1'b0,1'b1,1'b0,11'h000, 2'b10,11'h102,1'b1,1'b0,1'b1}, // R6
        '{1'b1,1'b0,1'b1,11'h103, 2'b11,11'h102,1'b1,1'b0,1'b1}, // R2 R5
        '{1'b0,1'b1,1'b0,11'h000, 2'b01,11'h103,1'b1,1'b1,1'b1}, // R5
        '{1'b1,1'b1,1'b0,11'h104, 2'b01,11'h104,1'b1,1'b0,1'b1}, // R9
        '{1'b0,1'b1,1'b0,11'h000, 2'b00,11'h104,1'b0,1'b0,1'b1}, // R6
        '{1'b0,1'b1,1'b0,11'h000, 2'b00,11'h104,1'b0,1'b0,1'b1}, // R6
        '{1'b1,1'b0,1'b0,11'h7FF, 2'b01,11'h7FF,1'b1,1'b0,1'b1}  // R1
    };

    function automatic logic [63:0] dat(input logic [10:0] id);
        return {8{id[7:0]}} ^ 64'h0011223344556677;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic rl, input logic rm, input logic [10:0] id,
                        input logic [3:0] dlc, input logic [63:0] d, input logic clr);
        @(negedge clk);
        store_i = st; rel_i = rl; st_rmt_i = rm; st_id_i = id;
        st_dlc_i = dlc; st_data_i = d; lost_clr_i = clr;
        @(posedge clk);
        #1;
        store_i = 1'b0; rel_i = 1'b0; lost_clr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 alloc", alloc_o, 0);
        chk("R10 flags", {newdat_o, rmtpnd_o, intpnd_o, msglst_o}, 0);
        chk("R10 code", irq_code_o, 0);
        chk("R10 data", data_o, 0);
        chk("R10 id", id_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (TBL[i]) begin
            step(TBL[i].st, TBL[i].rl, TBL[i].rm, TBL[i].id, 4'd8, dat(TBL[i].id), 1'b0);
            chk("R1-table alloc R2 R3 R6", alloc_o, TBL[i].e_alloc);
            chk("R5 table id", id_o, TBL[i].e_id);
            chk("R5 table newdat", newdat_o, TBL[i].e_nd);
            chk("R5 table rmtpnd", rmtpnd_o, TBL[i].e_rm);
            chk("R8 table lost", msglst_o, TBL[i].e_lost);
        end
        chk("R4 data frame bytes", data_o, dat(11'h7FF));

        // Reset again for directed tests.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 re-reset lost", msglst_o, 0);
        chk("R10 re-reset alloc", alloc_o, 0);
        rst_n = 1'b1;

        // R7: interrupt code follows enable and allocation
        rx_ie_i = 1'b0;
        step(1'b1, 1'b0, 1'b0, 11'h055, 4'd8, dat(11'h055), 1'b0);
        chk("R7 code disabled", irq_code_o, 8'h00);
        chk("R5 intpnd disabled", intpnd_o, 0);
        rx_ie_i = 1'b1; #1;
        chk("R7 code enabled", irq_code_o, 8'h02);
        chk("R5 intpnd enabled", intpnd_o, 1);
        step(1'b0, 1'b1, 1'b0, 11'h0, 4'd0, 64'h0, 1'b0);
        chk("R7 code after release", irq_code_o, 8'h00);

        // R4: remote frame into buffer 1 keeps old dlc and data
        step(1'b1, 1'b0, 1'b1, 11'h066, 4'd3, 64'hDEAD, 1'b0);
        chk("R4 remote id", id_o, 11'h066);
        chk("R4 remote dlc kept", dlc_o, 4'd8);
        chk("R4 remote data kept", data_o, dat(11'h055));
        chk("R4 remote rmtpnd", rmtpnd_o, 1);
        step(1'b0, 1'b1, 1'b0, 11'h0, 4'd0, 64'h0, 1'b0);

        // R8: sticky lost flag, set wins over clear
        step(1'b1, 1'b0, 1'b0, 11'h0A1, 4'd2, dat(11'h0A1), 1'b0);
        step(1'b1, 1'b0, 1'b0, 11'h0A2, 4'd2, dat(11'h0A2), 1'b0);
        step(1'b1, 1'b0, 1'b0, 11'h0A3, 4'd2, dat(11'h0A3), 1'b0);
        chk("R8 lost set", msglst_o, 1);
        step(1'b0, 1'b0, 1'b0, 11'h0, 4'd0, 64'h0, 1'b0);
        chk("R8 lost held", msglst_o, 1);
        step(1'b0, 1'b0, 1'b0, 11'h0, 4'd0, 64'h0, 1'b1);
        chk("R8 lost cleared", msglst_o, 0);
        step(1'b1, 1'b0, 1'b0, 11'h0A4, 4'd2, dat(11'h0A4), 1'b1);
        chk("R8 set wins over clear", msglst_o, 1);
        chk("R3 older kept", id_o, 11'h0A1);
        step(1'b0, 1'b0, 1'b0, 11'h0, 4'd0, 64'h0, 1'b1);
        chk("R8 lost cleared again", msglst_o, 0);

        // R9: release and store together with both full
        step(1'b1, 1'b1, 1'b0, 11'h0A5, 4'd5, dat(11'h0A5), 1'b0);
        chk("R9 no lost", msglst_o, 0);
        chk("R9 alloc", alloc_o, 2'b11);
        chk("R9 visible older", id_o, 11'h0A4);
        step(1'b0, 1'b1, 1'b0, 11'h0, 4'd0, 64'h0, 1'b0);
        chk("R9 next visible", id_o, 11'h0A5);
        chk("R9 next dlc", dlc_o, 4'd5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule